// File: doc/BRIEF.md
# Register Request to Settings Bus Bridge

This block sits between a single-beat register request port and the per-channel configuration buses of a multi-channel signal-processing block. A request carries a write strobe, a read strobe, a 20-bit byte address, 32-bit write data, and an optional 64-bit timestamp with a has-time flag. The bridge splits the byte address into a channel number and a register index. A write becomes a one-cycle strobe on that channel's settings bus, and the index, data and timestamp are held beside the strobe. A read presents the index on the channel's readback address and takes one word from the 64-bit readback value that comes back.

Each channel owns a 2048-byte window, and registers sit on an 8-byte stride. A 64-bit readback value is fetched as two 32-bit reads: byte offset +0 of a register gives the low word and offset +4 gives the high word. The readback source is always ready, so its data is valid in the cycle after the readback address changes. Only one request is outstanding at a time. The requester waits for the acknowledge before it issues the next request. Requests aimed past the last configured channel are still acknowledged; they have no effect on any channel.

Top module: `csb_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, resp_ack, set_stb, resp_data, every set_addr, set_data, set_time, set_has_time and every rb_addr are all zero.
- R2: A write sampled at a rising edge loads set_addr and set_data of channel c = req_addr[19:11] with index req_addr[10:3] and req_data. The new values are visible right after that edge and are held until the next write to that channel.
- R3: Each write pulses set_stb for exactly one cycle, only on bit c, in the cycle after the request. No other cycle has any set_stb bit high, and the settings outputs of the other channels do not change.
- R4: A write to channel c copies req_time into set_time of channel c and req_has_time into set_has_time of channel c, together with the strobe.
- R5: A write is acknowledged by resp_ack in the second cycle after the request, which is the cycle after the strobe. resp_data is zero in that cycle.
- R6: A read of channel c loads rb_addr of channel c with req_addr[10:3] in the cycle after the request. In the second cycle after the request it returns, with resp_ack, bits [31:0] of that channel's rb_data when req_addr[2] is 0, and bits [63:32] when req_addr[2] is 1.
- R7: When req_addr[19:11] is not below NUM_CH, the request is still acknowledged at the same time. A write strobes no channel and changes no settings output. A read leaves every rb_addr unchanged and returns zero data.
- R8: A request with both req_wr and req_rd high is handled as a write only, and rb_addr does not change.
- R9: resp_ack is high for exactly one cycle per request and is never high without a request two cycles earlier. resp_data is zero whenever resp_ack is low.
- R10: req_addr[1:0] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write request strobe |
| req_rd | input | 1 | Read request strobe |
| req_addr | input | 20 | Byte address: channel, register index, word half |
| req_data | input | 32 | Write data |
| req_has_time | input | 1 | Timestamp of the request is valid |
| req_time | input | 64 | Request timestamp |
| resp_ack | output | 1 | One-cycle acknowledge |
| resp_data | output | 32 | Read data returned with the acknowledge |
| set_addr | output | 8*NUM_CH | Per-channel settings register index |
| set_data | output | 32*NUM_CH | Per-channel settings data |
| set_stb | output | NUM_CH | Per-channel settings write strobe |
| set_time | output | 64*NUM_CH | Per-channel timestamp of the last write |
| set_has_time | output | NUM_CH | Per-channel has-time flag of the last write |
| rb_addr | output | 8*NUM_CH | Per-channel readback index |
| rb_data | input | 64*NUM_CH | Per-channel readback value, valid one cycle after rb_addr |

## Verification
A request sampled at a rising edge affects the outputs in two steps. The settings outputs, set_stb and rb_addr change right after that edge. resp_ack and resp_data change one edge later, so two register stages lie between the request and its answer. The bench's behavioural model applies exactly those two steps at every rising edge. All outputs are compared at the falling edge that follows, so every result is checked in the cycle it is due and in every cycle where it must stay quiet. Requests are spaced so that each one starts only after the previous acknowledge has been seen.

// File: rtl/csb_pkg.sv
package csb_pkg;

    // Fixed interface geometry of the register request port
    localparam int CP_ADDR_W  = 20;
    localparam int CP_DATA_W  = 32;
    localparam int TS_W       = 64;
    localparam int REG_IDX_W  = 8;
    localparam int RB_W       = 2 * CP_DATA_W;
    localparam int STRIDE_LSB = 3;                         // 8-byte register stride
    localparam int HALF_BIT   = 2;                         // selects the upper readback word
    localparam int WIN_LSB    = STRIDE_LSB + REG_IDX_W;    // 2048-byte channel window
    localparam int CH_FIELD_W = CP_ADDR_W - WIN_LSB;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef struct packed {
        op_e                   op;
        logic [CH_FIELD_W-1:0] ch;
        logic [REG_IDX_W-1:0]  idx;
        logic                  upper;
    } dec_req_t;

    typedef struct packed {
        logic [REG_IDX_W-1:0] idx;
        logic [CP_DATA_W-1:0] data;
        logic [TS_W-1:0]      tstamp;
        logic                 has_time;
    } set_word_t;

    // Write wins over read when both strobes are high
    function automatic dec_req_t split_addr(input logic wr, input logic rd,
                                            input logic [CP_ADDR_W-1:0] a);
        dec_req_t d;
        d.op    = wr ? OP_WRITE : (rd ? OP_READ : OP_NONE);
        d.ch    = a[CP_ADDR_W-1:WIN_LSB];
        d.idx   = a[WIN_LSB-1:STRIDE_LSB];
        d.upper = a[HALF_BIT];
        return d;
    endfunction

    function automatic logic [CP_DATA_W-1:0] half_of(input logic [RB_W-1:0] v,
                                                     input logic upper);
        return upper ? v[RB_W-1:CP_DATA_W] : v[CP_DATA_W-1:0];
    endfunction

endpackage

// File: rtl/csb_req_decode.sv
module csb_req_decode
    import csb_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                 wr,
    input  logic                 rd,
    input  logic [CP_ADDR_W-1:0] addr,
    output dec_req_t             req,
    output logic [NUM_CH-1:0]    hit,
    output logic                 in_range
);

    logic [HALF_BIT-1:0] unused_low;

    assign req        = split_addr(wr, rd, addr);
    assign unused_low = addr[HALF_BIT-1:0];

    // One comparator per configured channel; higher channel numbers hit nothing
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign hit[c] = (req.op != OP_NONE) && (req.ch == CH_FIELD_W'(c));
    end

    assign in_range = |hit;

endmodule

// File: rtl/csb_chan_regs.sv
module csb_chan_regs
    import csb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_sel,
    input  logic                 rd_sel,
    input  set_word_t            wword,
    output set_word_t            held,
    output logic                 stb,
    output logic [REG_IDX_W-1:0] rb_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            stb    <= 1'b0;
            rb_idx <= '0;
        end else begin
            stb <= wr_sel;
            if (wr_sel) begin
                held <= wword;
            end
            if (rd_sel) begin
                rb_idx <= wword.idx;
            end
        end
    end

endmodule

// File: rtl/csb_resp.sv
module csb_resp
    import csb_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  op_e                    op,
    input  logic [SEL_W-1:0]       sel,
    input  logic                   upper,
    input  logic                   in_range,
    input  logic [NUM_CH*RB_W-1:0] rb_flat,
    output logic                   ack,
    output logic [CP_DATA_W-1:0]   data
);

    op_e              pend_op;
    logic [SEL_W-1:0] pend_sel;
    logic             pend_upper;
    logic             pend_ok;
    logic [RB_W-1:0]  rb_sel;

    // Readback value of the pending channel, one cycle after its index was driven
    always_comb begin
        rb_sel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (pend_sel == SEL_W'(c)) begin
                rb_sel = rb_flat[c*RB_W +: RB_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_op    <= OP_NONE;
            pend_sel   <= '0;
            pend_upper <= 1'b0;
            pend_ok    <= 1'b0;
            ack        <= 1'b0;
            data       <= '0;
        end else begin
            pend_op    <= op;
            pend_sel   <= sel;
            pend_upper <= upper;
            pend_ok    <= in_range;
            ack        <= (pend_op != OP_NONE);
            data       <= (pend_op == OP_READ && pend_ok) ? half_of(rb_sel, pend_upper) : '0;
        end
    end

endmodule

// File: rtl/csb_bridge.sv
module csb_bridge
    import csb_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_wr,
    input  logic                        req_rd,
    input  logic [CP_ADDR_W-1:0]        req_addr,
    input  logic [CP_DATA_W-1:0]        req_data,
    input  logic                        req_has_time,
    input  logic [TS_W-1:0]             req_time,
    output logic                        resp_ack,
    output logic [CP_DATA_W-1:0]        resp_data,
    output logic [NUM_CH*REG_IDX_W-1:0] set_addr,
    output logic [NUM_CH*CP_DATA_W-1:0] set_data,
    output logic [NUM_CH-1:0]           set_stb,
    output logic [NUM_CH*TS_W-1:0]      set_time,
    output logic [NUM_CH-1:0]           set_has_time,
    output logic [NUM_CH*REG_IDX_W-1:0] rb_addr,
    input  logic [NUM_CH*RB_W-1:0]      rb_data
);

    dec_req_t          req;
    logic [NUM_CH-1:0] hit;
    logic              in_range;
    set_word_t         wword;

    csb_req_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr       (req_wr),
        .rd       (req_rd),
        .addr     (req_addr),
        .req      (req),
        .hit      (hit),
        .in_range (in_range)
    );

    assign wword = '{idx: req.idx, data: req_data, tstamp: req_time, has_time: req_has_time};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        set_word_t            held;
        logic [REG_IDX_W-1:0] rbi;

        csb_chan_regs u_regs (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (hit[c] && (req.op == OP_WRITE)),
            .rd_sel (hit[c] && (req.op == OP_READ)),
            .wword  (wword),
            .held   (held),
            .stb    (set_stb[c]),
            .rb_idx (rbi)
        );

        assign set_addr[c*REG_IDX_W +: REG_IDX_W] = held.idx;
        assign set_data[c*CP_DATA_W +: CP_DATA_W] = held.data;
        assign set_time[c*TS_W +: TS_W]           = held.tstamp;
        assign set_has_time[c]                    = held.has_time;
        assign rb_addr[c*REG_IDX_W +: REG_IDX_W]  = rbi;
    end

    csb_resp #(.NUM_CH(NUM_CH)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .op       (req.op),
        .sel      (req.ch[SEL_W-1:0]),
        .upper    (req.upper),
        .in_range (in_range),
        .rb_flat  (rb_data),
        .ack      (resp_ack),
        .data     (resp_data)
    );

endmodule

// File: rtl/csb_bridge_chk.sv
module csb_bridge_chk
    import csb_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_wr,
    input logic                 req_rd,
    input logic [CP_ADDR_W-1:0] req_addr,
    input logic                 resp_ack,
    input logic [CP_DATA_W-1:0] resp_data,
    input logic [NUM_CH-1:0]    set_stb
);

    logic [CH_FIELD_W:0] ch_of;
    logic                oor;

    assign ch_of = {1'b0, req_addr[CP_ADDR_W-1:WIN_LSB]};
    assign oor   = (ch_of >= (CH_FIELD_W+1)'(NUM_CH));

    p_stb_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_stb));

    p_idle_no_stb_r3: assert property (@(posedge clk) disable iff (rst)
        !req_wr |=> (set_stb == '0));

    p_wr_one_stb_r2: assert property (@(posedge clk) disable iff (rst)
        (req_wr && !oor) |=> ($countones(set_stb) == 1));

    p_oor_no_stb_r7: assert property (@(posedge clk) disable iff (rst)
        (req_wr && oor) |=> (set_stb == '0));

    p_req_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (req_wr || req_rd) |-> ##2 resp_ack);

    p_wr_ack_zero_r5: assert property (@(posedge clk) disable iff (rst)
        req_wr |-> ##2 (resp_data == '0));

    p_oor_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (req_rd && !req_wr && oor) |-> ##2 (resp_data == '0));

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        resp_ack |=> !resp_ack);

    p_quiet_data_r9: assert property (@(posedge clk) disable iff (rst)
        !resp_ack |-> (resp_data == '0));

endmodule

bind csb_bridge csb_bridge_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .resp_ack  (resp_ack),
    .resp_data (resp_data),
    .set_stb   (set_stb)
);

// File: tb/tb_csb_bridge.sv
`timescale 1ns/1ps
module tb_csb_bridge;

    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_wr = 1'b0;
    logic              req_rd = 1'b0;
    logic [19:0]       req_addr = '0;
    logic [31:0]       req_data = '0;
    logic              req_has_time = 1'b0;
    logic [63:0]       req_time = '0;
    logic              resp_ack;
    logic [31:0]       resp_data;
    logic [NCH*8-1:0]  set_addr;
    logic [NCH*32-1:0] set_data;
    logic [NCH-1:0]    set_stb;
    logic [NCH*64-1:0] set_time;
    logic [NCH-1:0]    set_has_time;
    logic [NCH*8-1:0]  rb_addr;
    logic [NCH*64-1:0] rb_data;

    always #10 clk = ~clk;   // 50 MHz

    // Readback source of the neighbouring block: combinational, always ready
    function automatic logic [63:0] rb_model(input int ch, input logic [7:0] idx);
        case (idx)
            8'd0:    return {32'hA5A5_0000 | 32'(ch), 32'h0000_5A5A};
            8'd1:    return 64'(ch + 1);
            8'd2:    return 64'd128 << ch;
            default: return 64'h0BAD_C0DE_0BAD_C0DE;
        endcase
    endfunction

    for (genvar g = 0; g < NCH; g++) begin : g_rb
        assign rb_data[g*64 +: 64] = rb_model(g, rb_addr[g*8 +: 8]);
    end

    csb_bridge #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
        .req_data(req_data), .req_has_time(req_has_time), .req_time(req_time),
        .resp_ack(resp_ack), .resp_data(resp_data), .set_addr(set_addr),
        .set_data(set_data), .set_stb(set_stb), .set_time(set_time),
        .set_has_time(set_has_time), .rb_addr(rb_addr), .rb_data(rb_data)
    );

    int    checks = 0;
    int    errors = 0;
    bit    chk_en = 0;
    bit    done = 0;
    int    cyc = 0;
    string phase = "R1";

    // Behavioural reference model
    logic [7:0]     m_addr   [NCH];
    logic [31:0]    m_data   [NCH];
    logic [63:0]    m_time   [NCH];
    logic           m_ht     [NCH];
    logic [7:0]     m_rbaddr [NCH];
    logic [NCH-1:0] m_stb = '0;
    logic           m_ack = 1'b0;
    logic [31:0]    m_rdata = '0;
    bit             m_pend = 0;
    bit             m_prd = 0;
    bit             m_pup = 0;
    int             m_pch = 0;
    int             mch;
    logic [63:0]    mv;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_addr[c] = '0; m_data[c] = '0; m_time[c] = '0; m_ht[c] = 1'b0; m_rbaddr[c] = '0;
            end
            m_stb = '0; m_ack = 1'b0; m_rdata = '0; m_pend = 0;
        end else begin
            m_stb = '0; m_ack = 1'b0; m_rdata = '0;
            if (m_pend) begin
                m_ack = 1'b1;
                if (m_prd && m_pch < NCH) begin
                    mv = rb_model(m_pch, m_rbaddr[m_pch]);
                    m_rdata = m_pup ? mv[63:32] : mv[31:0];
                end
                m_pend = 0;
            end
            if (req_wr || req_rd) begin
                mch = int'(req_addr[19:11]);
                if (req_wr) begin
                    if (mch < NCH) begin
                        m_addr[mch] = req_addr[10:3];
                        m_data[mch] = req_data;
                        m_time[mch] = req_time;
                        m_ht[mch]   = req_has_time;
                        m_stb[mch]  = 1'b1;
                    end
                end else if (mch < NCH) begin
                    m_rbaddr[mch] = req_addr[10:3];
                end
                m_pend = 1; m_prd = !req_wr; m_pch = mch; m_pup = req_addr[2];
            end
        end
    end

    task automatic chk(input string rq, input string name, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %h expected %h", rq, phase, name, act, exp);
        end
    endtask

    // Compare every output at each falling edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk("R3", "set_stb", 64'(set_stb), 64'(m_stb));
            chk("R9", "resp_ack", 64'(resp_ack), 64'(m_ack));
            chk("R6", "resp_data", 64'(resp_data), 64'(m_rdata));
            for (int c = 0; c < NCH; c++) begin
                chk("R2", "set_addr", 64'(set_addr[c*8 +: 8]), 64'(m_addr[c]));
                chk("R2", "set_data", 64'(set_data[c*32 +: 32]), 64'(m_data[c]));
                chk("R4", "set_time", set_time[c*64 +: 64], m_time[c]);
                chk("R4", "set_has_time", 64'(set_has_time[c]), 64'(m_ht[c]));
                chk("R6", "rb_addr", 64'(rb_addr[c*8 +: 8]), 64'(m_rbaddr[c]));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [19:0] mk_addr(input int ch, input int idx, input bit upper,
                                            input int low);
        return 20'((ch << 11) | ((idx & 255) << 3) | (int'(upper) << 2) | (low & 3));
    endfunction

    task automatic do_req(input bit wr, input bit rd, input logic [19:0] a,
                          input logic [31:0] d, input bit ht, input logic [63:0] t);
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = a; req_data = d; req_has_time = ht; req_time = t;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        req_addr = 20'hFFFFF; req_data = 32'hDEAD_BEEF; req_time = ~t;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk("R1", "resp_ack", 64'(resp_ack), 64'd0);
        chk("R1", "set_stb", 64'(set_stb), 64'd0);
        chk("R1", "resp_data", 64'(resp_data), 64'd0);
        chk("R1", "rb_addr", 64'(rb_addr), 64'd0);
        chk("R1", "set_addr", 64'(set_addr), 64'd0);
        chk("R1", "set_has_time", 64'(set_has_time), 64'd0);
        rst = 1'b0;
        chk_en = 1;
        @(negedge clk);

        phase = "R2";
        for (int c = 0; c < NCH; c++) begin
            do_req(1, 0, mk_addr(c, 16 * c + 5, 0, 0), 32'h1000_0000 + 32'(c), 0, 64'd0);
            do_req(1, 0, mk_addr(c, 255 - c, 1, 0), 32'hCAFE_0000 ^ 32'(c << 8), 0, 64'd0);
        end

        phase = "R4";
        do_req(1, 0, mk_addr(1, 131, 0, 0), 32'h0000_4000, 1, 64'h0123_4567_89AB_CDEF);
        do_req(1, 0, mk_addr(0, 132, 0, 0), 32'h0, 1, 64'hFEDC_BA98_7654_3210);
        do_req(1, 0, mk_addr(1, 133, 0, 0), 32'h7, 0, 64'h5555_AAAA_5555_AAAA);

        phase = "R6";
        for (int c = 0; c < NCH; c++) begin
            for (int idx = 0; idx < 4; idx++) begin
                do_req(0, 1, mk_addr(c, idx, 0, 0), 32'h0, 0, 64'd0);
                do_req(0, 1, mk_addr(c, idx, 1, 0), 32'h0, 0, 64'd0);
            end
            do_req(0, 1, mk_addr(c, 200, 1, 0), 32'h0, 0, 64'd0);
        end

        phase = "R7";
        do_req(1, 0, mk_addr(NCH, 9, 0, 0), 32'hBBBB_BBBB, 1, 64'd77);
        do_req(1, 0, mk_addr(511, 255, 1, 3), 32'hCCCC_CCCC, 1, 64'd99);
        do_req(0, 1, mk_addr(NCH, 0, 0, 0), 32'h0, 0, 64'd0);
        do_req(0, 1, mk_addr(300, 2, 1, 0), 32'h0, 0, 64'd0);

        phase = "R8";
        do_req(1, 1, mk_addr(2, 1, 1, 0), 32'h8888_0001, 1, 64'd8);
        do_req(1, 1, mk_addr(0, 3, 0, 0), 32'h8888_0002, 0, 64'd9);

        phase = "R10";
        do_req(1, 0, mk_addr(1, 42, 0, 3), 32'h1010_1010, 0, 64'd0);
        do_req(0, 1, mk_addr(2, 0, 0, 1), 32'h0, 0, 64'd0);
        do_req(0, 1, mk_addr(2, 0, 1, 2), 32'h0, 0, 64'd0);

        phase = "R9";
        repeat (5) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule